// File: doc/BRIEF.md
# Clock-Synchronous Serial Master Transceiver

This block is an 8-bit serial master that talks to a clock-synchronous peripheral. A host loads a byte into a transmit holding register. When the shift engine is idle, it takes that byte and drives exactly eight serial clock cycles. On each cycle it sends one bit on the transmit line and captures one bit from the receive line. The received byte is placed in a receive holding register, and a full flag is raised. If a frame completes while that flag is still set, a sticky overrun flag is raised.

Four static controls set the line format:
- bit order, least or most significant first;
- which serial clock edge launches data and which edge captures it;
- optional inversion of the data bits on both directions;
- the half-period of the serial clock, in system clocks.

Continuous receive mode is for read-only traffic. In this mode, a host read of the receive register marks the transmit register as loaded again. That launches the next frame, which repeats the last byte written, so the host never has to write filler bytes. Only the first frame needs a write.

Top module: `sst_xcvr`

## Requirements
- R1: With `cfg_msb_first`=0, serial slot k (k=0..7) carries byte bit k. With `cfg_msb_first`=1, slot k carries bit 7-k. The same mapping applies to transmit and receive.
- R2: With `cfg_ckpol`=0, `sclk` idles high, `txd` is updated on the falling edge, and `rxd` is captured on the rising edge. With `cfg_ckpol`=1, `sclk` idles low and both edges swap roles.
- R3: With `cfg_invert`=1, every data bit on `txd` is the complement of the byte bit, and every `rxd` bit is complemented before it is stored. With `cfg_invert`=0, no bit is changed.
- R4: A frame has exactly eight serial clock cycles. Each half-period lasts `cfg_div`+1 system clocks.
- R5: A write clears `tx_empty` in the next cycle. When the idle engine takes the byte, `tx_empty` returns to 1 one cycle later.
- R6: Frame completion sets `rx_full`, and `rd_data` then holds the received byte. A read pulse clears `rx_full`.
- R7: A frame that completes while `rx_full`=1 sets the sticky `overrun` flag, unless a read pulse falls in the same cycle as the completion. In that case `rx_full` stays 1, the new byte is stored, and `overrun` is unchanged.
- R8: With `cfg_cont_rx`=1, a read pulse clears `tx_empty` and starts a new frame. That frame transmits the last byte written.
- R9: After reset, `tx_empty`=1, `rx_full`=0, `overrun`=0, `txd`=1, and `sclk` is at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_msb_first | input | 1 | Bit order select |
| cfg_ckpol | input | 1 | Clock edge role select |
| cfg_invert | input | 1 | Data inversion on both paths |
| cfg_cont_rx | input | 1 | Continuous receive mode |
| cfg_div | input | DIV_W | Half-period minus one, in system clocks |
| wr_en | input | 1 | Write pulse for the transmit register |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read pulse for the receive register |
| rd_data | output | 8 | Received byte |
| tx_empty | output | 1 | Transmit register is free |
| rx_full | output | 1 | Receive register holds an unread byte |
| overrun | output | 1 | Sticky lost-byte flag |
| sclk | output | 1 | Serial clock |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
The host read and frame completion can land in the same system cycle. The bench provokes this by first leaving one byte unread. During the next frame, it counts the divider half-period from the last launch edge and places the read pulse exactly on the completing capture edge. It then requires `rx_full` to remain 1, `rd_data` to show the new byte, and `overrun` to stay clear. A separate run without the read pulse confirms that the same situation does raise `overrun`.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  // serial slot -> byte bit index
  function automatic logic [CNT_W-1:0] slot_pos(input logic msb_first,
                                                input logic [CNT_W-1:0] slot);
    return msb_first ? CNT_W'(BYTE_W - 1) - slot : slot;
  endfunction

  function automatic logic line_bit(input logic b, input logic inv);
    return b ^ inv;
  endfunction

  // level the serial clock rests at between frames
  function automatic logic rest_level(input logic ckpol);
    return ~ckpol;
  endfunction
endpackage

// File: rtl/sst_clkdiv.sv
module sst_clkdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= div)); // R4
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              msb_first,
  input  logic              ckpol,
  input  logic              invert,
  input  logic              rxd,
  input  logic              tick,
  output logic              active,
  output logic              done,
  output logic [BYTE_W-1:0] rx_word,
  output logic              sclk,
  output logic              txd
);
  logic [BYTE_W-1:0] tx_sh, rx_sh;
  logic [CNT_W-1:0]  slot;
  logic              phase;   // 1: between launch edge and capture edge
  logic              last_slot;

  assign last_slot = (slot == CNT_W'(BYTE_W - 1));
  assign done      = active && tick && phase && last_slot;
  assign sclk      = (active && phase) ? ~rest_level(ckpol) : rest_level(ckpol);

  always_comb begin
    rx_word = rx_sh;
    rx_word[slot_pos(msb_first, slot)] = line_bit(rxd, invert);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= 1'b0;
      slot   <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      txd    <= 1'b1;
    end else if (start) begin
      active <= 1'b1;
      phase  <= 1'b0;
      slot   <= '0;
      tx_sh  <= load_data;
    end else if (active && tick) begin
      if (!phase) begin
        phase <= 1'b1;
        txd   <= line_bit(tx_sh[slot_pos(msb_first, slot)], invert);
      end else begin
        phase <= 1'b0;
        rx_sh <= rx_word;
        if (last_slot) begin
          active <= 1'b0;
          txd    <= 1'b1;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

  AST_TXD_REST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> txd); // R9
  AST_EIGHT_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active); // R4
endmodule

// File: rtl/sst_xcvr.sv
module sst_xcvr
  import sst_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_msb_first,
  input  logic              cfg_ckpol,
  input  logic              cfg_invert,
  input  logic              cfg_cont_rx,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              overrun,
  output logic              sclk,
  output logic              txd,
  input  logic              rxd
);
  logic [BYTE_W-1:0] tx_buf, rx_word;
  logic active, done, tick, start, rearm;

  assign start = !active && !tx_empty;
  assign rearm = cfg_cont_rx && rd_en;

  sst_clkdiv #(.DIV_W(DIV_W)) i_div (
    .clk(clk), .rst_n(rst_n), .run(active), .div(cfg_div), .tick(tick));

  sst_shifter i_shf (
    .clk(clk), .rst_n(rst_n), .start(start), .load_data(tx_buf),
    .msb_first(cfg_msb_first), .ckpol(cfg_ckpol), .invert(cfg_invert),
    .rxd(rxd), .tick(tick), .active(active), .done(done),
    .rx_word(rx_word), .sclk(sclk), .txd(txd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf   <= '0;
      tx_empty <= 1'b1;
    end else begin
      if (wr_en) tx_buf <= wr_data;
      if (wr_en || rearm) tx_empty <= 1'b0;
      else if (start)     tx_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rx_full <= 1'b0;
      overrun <= 1'b0;
    end else if (done) begin
      rd_data <= rx_word;
      rx_full <= 1'b1;
      if (rx_full && !rd_en) overrun <= 1'b1;
    end else if (rd_en) begin
      rx_full <= 1'b0;
    end
  end

  AST_FULL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_full); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !done) |=> !rx_full); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R7
  AST_CONT_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !tx_empty); // R8
  AST_EMPTY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wr_en && !rearm) |=> tx_empty); // R5
endmodule

// File: tb/test_sst_xcvr.sv
module test_sst_xcvr;
  logic clk = 0, rst_n = 0;
  logic msb = 0, pol = 0, inv = 0, cont = 0;
  logic [7:0] div = 0;
  logic wr_en = 0, rd_en = 0, rxd = 1;
  logic [7:0] wr_data = 0, rd_data;
  logic tx_empty, rx_full, overrun, sclk, txd;
  int tests = 0, fails = 0, cyc = 0;
  bit hung = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sst_xcvr i_sst_xcvr (
    .clk(clk), .rst_n(rst_n), .cfg_msb_first(msb), .cfg_ckpol(pol),
    .cfg_invert(inv), .cfg_cont_rx(cont), .cfg_div(div), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .tx_empty(tx_empty),
    .rx_full(rx_full), .overrun(overrun), .sclk(sclk), .txd(txd), .rxd(rxd));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pos(input logic m, input int k);
    return m ? 7 - k : k;
  endfunction

  task automatic host_write(input logic [7:0] d);
    wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    chk(tx_empty == 0, "R5 write clears empty", tx_empty, 0);
    @(negedge clk);
    chk(tx_empty == 1, "R5 load sets empty", tx_empty, 1);
  endtask

  task automatic host_read;
    rd_en = 1; @(negedge clk); rd_en = 0;
  endtask

  // slave model: answers rx, captures tx; optional read on the completing edge
  task automatic slave(input logic [7:0] rx, input bit rd_at_end,
                       output logic [7:0] got);
    int edges = 0, first = 0, last = 0, guard = 0;
    logic prev = sclk;
    got = 0;
    while (edges < 8 && guard < 5000) begin
      @(negedge clk); guard++;
      if (sclk != prev && sclk == pol) begin
        got[pos(msb, edges)] = txd ^ inv;
        rxd = rx[pos(msb, edges)] ^ inv;
        if (edges == 0) first = cyc;
        last = cyc;
        edges++;
      end
      prev = sclk;
    end
    if (guard >= 5000) hung = 1;
    chk(edges == 8, "R4 edge count", edges, 8);
    chk(last - first == 7 * 2 * (div + 1), "R4 half period", last - first, 7 * 2 * (div + 1));
    if (rd_at_end) begin
      repeat (div) @(negedge clk);
      rd_en = 1; @(negedge clk); rd_en = 0;
    end else begin
      repeat (div + 2) @(negedge clk);
    end
    chk(sclk == !pol, "R2 clock rests", sclk, !pol);
    chk(txd == 1, "R9 txd rests high", txd, 1);
  endtask

  initial begin
    logic [7:0] got, tb, rb;
    fork
      begin
        wait (cyc > 150000 || hung);
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    chk(tx_empty == 1 && rx_full == 0 && overrun == 0, "R9 reset flags",
        {tx_empty, rx_full, overrun}, 3'b100);
    chk(txd == 1 && sclk == 1, "R9 reset lines", {txd, sclk}, 2'b11);
    rst_n = 1; @(negedge clk);

    // sweep order, polarity, inversion, divider
    for (int c = 0; c < 24; c++) begin
      msb = c[0]; pol = c[1]; inv = c[2]; div = 8'(c / 8) * 2;
      tb = 8'h35 ^ 8'(c * 29); rb = 8'hC6 ^ 8'(c * 53);
      @(negedge clk);
      chk(sclk == !pol, "R2 idle level", sclk, !pol);
      host_write(tb);
      slave(rb, 0, got);
      chk(got == tb, "R1 R3 tx bits", got, tb);
      chk(rx_full == 1, "R6 full on done", rx_full, 1);
      chk(rd_data == rb, "R1 R3 rx byte", rd_data, rb);
      host_read;
      chk(rx_full == 0, "R6 read clears", rx_full, 0);
    end

    // R7: read coinciding with completion
    msb = 0; pol = 0; inv = 0; div = 3; @(negedge clk);
    host_write(8'h11); slave(8'h22, 0, got);
    host_write(8'h33); slave(8'h44, 1, got);
    chk(rx_full == 1 && overrun == 0, "R7 same-cycle read", {rx_full, overrun}, 2'b10);
    chk(rd_data == 8'h44, "R7 new byte kept", rd_data, 8'h44);
    // R7: overrun without read
    host_write(8'h55); slave(8'h66, 0, got);
    chk(overrun == 1, "R7 overrun set", overrun, 1);
    host_read; @(negedge clk);
    chk(overrun == 1, "R7 overrun sticky", overrun, 1);

    // R8: continuous receive
    rst_n = 0; @(negedge clk); rst_n = 1;
    cont = 1; msb = 1; pol = 1; inv = 1; div = 1; @(negedge clk);
    host_write(8'hA5); slave(8'h5A, 0, got);
    chk(got == 8'hA5, "R8 first frame", got, 8'hA5);
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk(tx_empty == 0, "R8 read rearms", tx_empty, 0);
    chk(rx_full == 0, "R8 read clears full", rx_full, 0);
    for (int n = 0; n < 3; n++) begin
      rb = 8'h0F + 8'(n * 71);
      slave(rb, 0, got);
      chk(got == 8'hA5, "R8 repeats last byte", got, 8'hA5);
      chk(rd_data == rb, "R8 rx byte", rd_data, rb);
      host_read;
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule